// File: doc/BRIEF.md
# I2C Burst FIFO Event Unit

This block sits between the register interface and the bus engine of an I2C master. It holds one byte FIFO for outgoing data and one for incoming data. Software moves bytes in bursts. The block tells software when a burst may be moved by raising level events, each derived from the FIFO fill levels, two programmed thresholds and a count of the bytes still to cross the bus.

A threshold value `t` defines a burst of `t+1` bytes. A ready event is raised when a full burst can be moved. A drain event is raised when the transfer is almost done and the last burst is shorter than a full one; software then reads the reported count to learn how many bytes to move. The bus engine pushes received bytes and pops bytes to transmit. Each byte it moves decrements the 16-bit transfer length that software loaded.

Top module: `burst_fifo_events`

## Requirements
- R1: After reset both FIFOs are empty, both thresholds are 0, the remaining length is 0, all four events are low and `buf_status` holds only the depth code.
- R2: A config write (`cfg_we`) takes the receive threshold from `cfg_wdata[13:8]` and the transmit threshold from `cfg_wdata[5:0]`. Each value is clamped to DEPTH-1.
- R3: A config write with `cfg_wdata[14]` set empties the receive FIFO, and one with `cfg_wdata[6]` set empties the transmit FIFO. A clear wins over a push or pop to the same FIFO in the same cycle.
- R4: Each FIFO returns bytes in push order on its head output. A push and a pop in the same cycle leave the count unchanged.
- R5: A push to a full FIFO is dropped. A pop from an empty FIFO changes nothing, and an empty FIFO shows 0x00 on its head output.
- R6: `buf_status` carries the receive count in bits 13:8, the transmit field in bits 5:0 and the depth code in bits 15:14 (0, 1 or 2 for a DEPTH of 8, 16 or 32). Bits 7:6 read 0.
- R7: A length write loads `len_wdata` into `remain`. A zero length is illegal and is ignored. A nonzero load wins over a same-cycle decrement.
- R8: In each cycle where the engine pops a transmit byte or pushes a receive byte and the push or pop is accepted, `remain` drops by one. It does not drop below 0.
- R9: `ev_rx_rdy` is high when the receive count is at least the receive threshold plus one.
- R10: `ev_rx_drain` is high when the receive FIFO is not empty and its count plus `remain` is less than the receive threshold plus one.
- R11: Pending transmit bytes are `remain` minus the transmit count, floored at 0. `ev_tx_rdy` is high when the free space and the pending bytes are both at least the transmit threshold plus one.
- R12: `ev_tx_drain` is high when the pending transmit bytes are between 1 and the transmit threshold and fit in the free space. While it is high, `buf_status[5:0]` reports the pending bytes instead of the transmit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Buffer configuration write strobe |
| cfg_wdata | input | 16 | Thresholds and FIFO clear bits |
| len_we | input | 1 | Transfer length write strobe |
| len_wdata | input | 16 | Transfer length in bytes |
| sw_tx_push | input | 1 | Software writes a transmit byte |
| sw_tx_data | input | 8 | Transmit byte from software |
| eng_tx_pop | input | 1 | Bus engine takes a transmit byte |
| eng_tx_data | output | 8 | Transmit FIFO head |
| eng_rx_push | input | 1 | Bus engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte from the engine |
| sw_rx_pop | input | 1 | Software reads a receive byte |
| sw_rx_data | output | 8 | Receive FIFO head |
| buf_status | output | 16 | Counts and depth code |
| remain | output | 16 | Bytes left in the programmed transfer |
| ev_tx_rdy | output | 1 | A full transmit burst may be written |
| ev_rx_rdy | output | 1 | A full receive burst may be read |
| ev_tx_drain | output | 1 | Final short transmit burst may be written |
| ev_rx_drain | output | 1 | Final short receive burst may be read |

## Verification
Software and the bus engine work on opposite ends of the same FIFO, so a push and a pop often land in one cycle. A config clear can also coincide with either of them. The random phase drives all four handshakes independently at about half rate, with occasional clears and length loads. A bench queue model holds the expected contents, counts, remaining length and events, and every output is compared each cycle. Directed cases fill the transmit FIFO past full, clear it while pushing, and load a zero length. In those cases the count must hold or drop to zero exactly as the rules above say.

// File: rtl/bfe_pkg.sv
package bfe_pkg;

  localparam int THR_W      = 6;
  localparam int RX_THR_LSB = 8;
  localparam int TX_THR_LSB = 0;
  localparam int RX_CLR_BIT = 14;
  localparam int TX_CLR_BIT = 6;

  typedef struct packed {
    logic [THR_W-1:0] rx_thr;
    logic [THR_W-1:0] tx_thr;
  } thr_cfg_t;

  // limit a threshold so one burst never exceeds the FIFO
  function automatic logic [THR_W-1:0] clamp_thr(input logic [THR_W-1:0] f, input int depth);
    if (int'(f) > depth - 1) return THR_W'(depth - 1);
    return f;
  endfunction

  // burst size for a threshold value
  function automatic logic [THR_W:0] burst_len(input logic [THR_W-1:0] thr);
    return {1'b0, thr} + 1'b1;
  endfunction

  // transmit bytes software has yet to write
  function automatic logic [15:0] pending_bytes(input logic [15:0] rem, input logic [15:0] held);
    return (rem > held) ? (rem - held) : 16'd0;
  endfunction

  function automatic logic [1:0] depth_code(input int depth);
    if (depth >= 32) return 2'd2;
    if (depth >= 16) return 2'd1;
    return 2'd0;
  endfunction

endpackage

// File: rtl/bfe_byte_fifo.sv
module bfe_byte_fifo #(
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         push,
  input  logic [7:0]                   push_data,
  input  logic                         pop,
  output logic [7:0]                   head,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         push_ok,
  output logic                         pop_ok
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          full, empty;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full && !clr;
  assign pop_ok  = pop && !empty && !clr;
  assign head    = empty ? 8'h00 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      unique case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/bfe_xfer_counter.sv
module bfe_xfer_counter (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [15:0] load_val,
  input  logic        step,
  output logic [15:0] remain
);
  logic load_ok;
  assign load_ok = load && (load_val != 16'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        remain <= 16'd0;
    else if (load_ok)                  remain <= load_val;
    else if (step && remain != 16'd0)  remain <= remain - 16'd1;
  end
endmodule

// File: rtl/bfe_thr_cfg.sv
module bfe_thr_cfg #(
  parameter int DEPTH = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [15:0]         wdata,
  output bfe_pkg::thr_cfg_t   cfg
);
  import bfe_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (we) begin
      cfg.rx_thr <= clamp_thr(wdata[RX_THR_LSB +: THR_W], DEPTH);
      cfg.tx_thr <= clamp_thr(wdata[TX_THR_LSB +: THR_W], DEPTH);
    end
  end
endmodule

// File: rtl/bfe_burst_events.sv
module bfe_burst_events #(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input  logic [CW-1:0] rx_cnt,
  input  logic [CW-1:0] tx_cnt,
  input  logic [5:0]    rx_thr,
  input  logic [5:0]    tx_thr,
  input  logic [15:0]   remain,
  output logic          ev_rx_rdy,
  output logic          ev_rx_drain,
  output logic          ev_tx_rdy,
  output logic          ev_tx_drain,
  output logic [15:0]   tx_pending
);
  import bfe_pkg::*;

  logic [6:0]  rx_burst, tx_burst, tx_space;
  logic [16:0] rx_total;

  assign rx_burst   = burst_len(rx_thr);
  assign tx_burst   = burst_len(tx_thr);
  assign rx_total   = 17'(rx_cnt) + 17'(remain);
  assign tx_space   = 7'(DEPTH) - 7'(tx_cnt);
  assign tx_pending = pending_bytes(remain, 16'(tx_cnt));

  assign ev_rx_rdy   = (7'(rx_cnt) >= rx_burst);
  assign ev_rx_drain = (rx_cnt != '0) && (rx_total < 17'(rx_burst));
  assign ev_tx_rdy   = (tx_space >= tx_burst) && (tx_pending >= 16'(tx_burst));
  assign ev_tx_drain = (tx_pending != 16'd0) && (tx_pending < 16'(tx_burst)) &&
                       (16'(tx_space) >= tx_pending);
endmodule

// File: rtl/burst_fifo_events.sv
module burst_fifo_events #(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [15:0] cfg_wdata,
  input  logic        len_we,
  input  logic [15:0] len_wdata,
  input  logic        sw_tx_push,
  input  logic [7:0]  sw_tx_data,
  input  logic        eng_tx_pop,
  output logic [7:0]  eng_tx_data,
  input  logic        eng_rx_push,
  input  logic [7:0]  eng_rx_data,
  input  logic        sw_rx_pop,
  output logic [7:0]  sw_rx_data,
  output logic [15:0] buf_status,
  output logic [15:0] remain,
  output logic        ev_tx_rdy,
  output logic        ev_rx_rdy,
  output logic        ev_tx_drain,
  output logic        ev_rx_drain
);
  import bfe_pkg::*;

  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [1:0] DCODE = depth_code(DEPTH);

  thr_cfg_t     cfg;
  logic         tx_clr, rx_clr;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic         tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;
  logic         xfer_step;
  logic [15:0]  tx_pending;
  logic [5:0]   tx_field;

  assign tx_clr    = cfg_we && cfg_wdata[TX_CLR_BIT];
  assign rx_clr    = cfg_we && cfg_wdata[RX_CLR_BIT];
  assign xfer_step = tx_pop_ok || rx_push_ok;

  bfe_thr_cfg #(.DEPTH(DEPTH)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .cfg(cfg)
  );

  bfe_byte_fifo #(.DEPTH(DEPTH)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr),
    .push(sw_tx_push), .push_data(sw_tx_data), .pop(eng_tx_pop),
    .head(eng_tx_data), .count(tx_cnt), .push_ok(tx_push_ok), .pop_ok(tx_pop_ok)
  );

  bfe_byte_fifo #(.DEPTH(DEPTH)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr),
    .push(eng_rx_push), .push_data(eng_rx_data), .pop(sw_rx_pop),
    .head(sw_rx_data), .count(rx_cnt), .push_ok(rx_push_ok), .pop_ok(rx_pop_ok)
  );

  bfe_xfer_counter u_len (
    .clk(clk), .rst_n(rst_n), .load(len_we), .load_val(len_wdata),
    .step(xfer_step), .remain(remain)
  );

  bfe_burst_events #(.DEPTH(DEPTH), .CW(CW)) u_events (
    .rx_cnt(rx_cnt), .tx_cnt(tx_cnt), .rx_thr(cfg.rx_thr), .tx_thr(cfg.tx_thr),
    .remain(remain), .ev_rx_rdy(ev_rx_rdy), .ev_rx_drain(ev_rx_drain),
    .ev_tx_rdy(ev_tx_rdy), .ev_tx_drain(ev_tx_drain), .tx_pending(tx_pending)
  );

  // final short transmit burst reports its own size
  assign tx_field   = ev_tx_drain ? tx_pending[5:0] : 6'(tx_cnt);
  assign buf_status = {DCODE, 6'(rx_cnt), 2'b00, tx_field};
endmodule

// File: rtl/bfe_checker.sv
module bfe_checker #(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [15:0]   cfg_wdata,
  input logic          len_we,
  input logic [15:0]   len_wdata,
  input logic          sw_tx_push,
  input logic          eng_tx_pop,
  input logic [7:0]    sw_rx_data,
  input logic [15:0]   remain,
  input logic          ev_rx_rdy,
  input logic          ev_rx_drain,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic          xfer_step
);
  // R3
  tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[6]) |=> (tx_cnt == '0));
  // R3
  rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[14]) |=> (rx_cnt == '0));
  // R4
  occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));
  // R5
  full_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt == CW'(DEPTH) && sw_tx_push && !eng_tx_pop && !(cfg_we && cfg_wdata[6]))
    |=> (tx_cnt == CW'(DEPTH)));
  // R5
  empty_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == '0) |-> (sw_rx_data == 8'h00));
  // R7
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (len_we && len_wdata == 16'd0 && !xfer_step) |=> $stable(remain));
  // R8
  step_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!len_we && xfer_step && remain != 16'd0) |=> (remain == $past(remain) - 16'd1));
  // R10
  rx_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_rx_rdy && ev_rx_drain));
endmodule

bind burst_fifo_events bfe_checker #(.DEPTH(DEPTH), .CW(CW)) u_bfe_checker (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .len_we(len_we), .len_wdata(len_wdata), .sw_tx_push(sw_tx_push),
  .eng_tx_pop(eng_tx_pop), .sw_rx_data(sw_rx_data), .remain(remain),
  .ev_rx_rdy(ev_rx_rdy), .ev_rx_drain(ev_rx_drain), .tx_cnt(tx_cnt),
  .rx_cnt(rx_cnt), .xfer_step(xfer_step)
);

// File: tb/burst_fifo_events_test.sv
`timescale 1ns/1ps
module burst_fifo_events_test;
  localparam int DEPTH = 8;
  localparam int RAND_CYCLES = 4000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, len_we = 0, sw_tx_push = 0, eng_tx_pop = 0, eng_rx_push = 0, sw_rx_pop = 0;
  logic [15:0] cfg_wdata = 0, len_wdata = 0;
  logic [7:0]  sw_tx_data = 0, eng_rx_data = 0;
  logic [7:0]  eng_tx_data, sw_rx_data;
  logic [15:0] buf_status, remain;
  logic ev_tx_rdy, ev_rx_rdy, ev_tx_drain, ev_rx_drain;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  logic [7:0] mtx[$];
  logic [7:0] mrx[$];
  int mrem = 0, mrthr = 0, mtthr = 0;

  always #4 clk = ~clk;

  burst_fifo_events #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .len_we(len_we), .len_wdata(len_wdata), .sw_tx_push(sw_tx_push),
    .sw_tx_data(sw_tx_data), .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
    .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data), .sw_rx_pop(sw_rx_pop),
    .sw_rx_data(sw_rx_data), .buf_status(buf_status), .remain(remain),
    .ev_tx_rdy(ev_tx_rdy), .ev_rx_rdy(ev_rx_rdy), .ev_tx_drain(ev_tx_drain),
    .ev_rx_drain(ev_rx_drain)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int pend_tx();
    int p = mrem - mtx.size();
    return (p < 0) ? 0 : p;
  endfunction
  function automatic int free_tx();
    return DEPTH - mtx.size();
  endfunction
  function automatic bit x_rx_rdy();   return mrx.size() > mrthr; endfunction
  function automatic bit x_rx_drain(); return mrx.size() > 0 && mrx.size() + mrem <= mrthr; endfunction
  function automatic bit x_tx_rdy();   return free_tx() > mtthr && pend_tx() > mtthr; endfunction
  function automatic bit x_tx_drain();
    return pend_tx() > 0 && pend_tx() <= mtthr && pend_tx() <= free_tx();
  endfunction
  function automatic int x_status();
    int txf = x_tx_drain() ? pend_tx() : mtx.size();
    int code = (DEPTH >= 32) ? 2 : (DEPTH >= 16) ? 1 : 0;
    return code * 16384 + mrx.size() * 256 + txf;
  endfunction

  task automatic compare_all();
    chk("R6 status", int'(buf_status), x_status());
    chk("R8 remain", int'(remain), mrem);
    chk("R9 rx_rdy", int'(ev_rx_rdy), int'(x_rx_rdy()));
    chk("R10 rx_drain", int'(ev_rx_drain), int'(x_rx_drain()));
    chk("R11 tx_rdy", int'(ev_tx_rdy), int'(x_tx_rdy()));
    chk("R12 tx_drain", int'(ev_tx_drain), int'(x_tx_drain()));
    chk("R4 tx head", int'(eng_tx_data), (mtx.size() > 0) ? int'(mtx[0]) : 0);
    chk("R5 rx head", int'(sw_rx_data), (mrx.size() > 0) ? int'(mrx[0]) : 0);
  endtask

  task automatic step(input bit cw, input logic [15:0] cwd, input bit lw, input logic [15:0] lwd,
                      input bit tpush, input logic [7:0] td, input bit tpop,
                      input bit rpush, input logic [7:0] rd, input bit rpop);
    bit txc, rxc, tpo, tpu, rpu, rpo;
    @(negedge clk);
    compare_all();
    cfg_we = cw; cfg_wdata = cwd; len_we = lw; len_wdata = lwd;
    sw_tx_push = tpush; sw_tx_data = td; eng_tx_pop = tpop;
    eng_rx_push = rpush; eng_rx_data = rd; sw_rx_pop = rpop;
    txc = cw && cwd[6];
    rxc = cw && cwd[14];
    tpo = !txc && tpop && mtx.size() > 0;
    tpu = !txc && tpush && mtx.size() < DEPTH;
    rpu = !rxc && rpush && mrx.size() < DEPTH;
    rpo = !rxc && rpop && mrx.size() > 0;
    if (txc) mtx.delete();
    else begin
      if (tpo) void'(mtx.pop_front());
      if (tpu) mtx.push_back(td);
    end
    if (rxc) mrx.delete();
    else begin
      if (rpo) void'(mrx.pop_front());
      if (rpu) mrx.push_back(rd);
    end
    if (lw && lwd != 0) mrem = int'(lwd);
    else if ((tpo || rpu) && mrem > 0) mrem--;
    if (cw) begin
      mrthr = (int'(cwd[13:8]) > DEPTH - 1) ? DEPTH - 1 : int'(cwd[13:8]);
      mtthr = (int'(cwd[5:0]) > DEPTH - 1) ? DEPTH - 1 : int'(cwd[5:0]);
    end
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic look();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_b0a7));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    look();
    chk("R1 status", int'(buf_status), 0);
    chk("R1 remain", int'(remain), 0);
    chk("R1 events", int'({ev_tx_rdy, ev_rx_rdy, ev_tx_drain, ev_rx_drain}), 0);

    // R2 threshold clamp: 63 becomes DEPTH-1, burst = DEPTH
    step(1, 16'h3f3f, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < DEPTH - 1; i++) step(0, 0, 0, 0, 0, 0, 0, 1, 8'(i + 8'h40), 0);
    look();
    chk("R2 rx_rdy below burst", int'(ev_rx_rdy), 0);
    step(0, 0, 0, 0, 0, 0, 0, 1, 8'h55, 0);
    look();
    chk("R2 rx_rdy at clamped burst", int'(ev_rx_rdy), 1);
    // R5 full rx push dropped
    step(0, 0, 0, 0, 0, 0, 0, 1, 8'h66, 0);
    look();
    chk("R5 rx count at full", int'(buf_status[13:8]), DEPTH);
    // R3 clear rx while popping
    step(1, 16'h4000, 0, 0, 0, 0, 0, 0, 0, 1);
    look();
    chk("R3 rx cleared", int'(buf_status[13:8]), 0);

    // R5 overfill tx with remain 0, then clear tx during a push
    for (int i = 0; i < DEPTH + 2; i++) step(0, 0, 0, 0, 1, 8'(i + 1), 0, 0, 0, 0);
    look();
    chk("R5 tx full push dropped", int'(buf_status[5:0]), DEPTH);
    step(1, 16'h0040, 0, 0, 1, 8'hAA, 0, 0, 0, 0);
    look();
    chk("R3 tx cleared over push", int'(buf_status[5:0]), 0);

    // R7 zero length ignored
    step(0, 0, 1, 16'd5, 0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 16'd0, 0, 0, 0, 0, 0, 0);
    look();
    chk("R7 zero length kept", int'(remain), 5);
    // R7 load wins over a same-cycle step
    step(0, 0, 1, 16'd9, 0, 0, 0, 1, 8'h11, 0);
    look();
    chk("R7 load over step", int'(remain), 9);
    // R4 same-cycle push and pop on rx keep count
    step(0, 0, 0, 0, 0, 0, 0, 1, 8'h22, 1);
    look();
    chk("R4 rx push+pop count", int'(buf_status[13:8]), 1);

    // R12 short final transmit burst
    step(1, 16'h0303, 1, 16'd2, 0, 0, 0, 0, 0, 0);
    look();
    chk("R12 tx_drain", int'(ev_tx_drain), 1);
    chk("R12 tx field pending", int'(buf_status[5:0]), 2);

    for (int c = 0; c < RAND_CYCLES; c++) begin
      bit cw, lw;
      logic [15:0] cwd, lwd;
      cw = ($urandom % 20) == 0;
      cwd = 16'h0;
      cwd[13:8] = 6'($urandom % 64);
      cwd[5:0]  = 6'($urandom % 64);
      cwd[14]   = ($urandom % 4) == 0;
      cwd[6]    = ($urandom % 4) == 0;
      lw = ($urandom % 25) == 0;
      lwd = 16'($urandom % 40);
      step(cw, cwd, lw, lwd, 1'($urandom % 2), 8'($urandom), 1'($urandom % 2),
           1'($urandom % 2), 8'($urandom), 1'($urandom % 2));
    end
    idle();
    idle();

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule